// File: doc/BRIEF.md
# Switchable-Memory Viterbi Decoder

This block recovers 64-bit packets protected by a rate one-half convolutional code, using hard decisions. Each packet may use a code with 4, 6 or 8 memory cells (constraint length 5, 7 or 9), which gives a trellis of 16, 64 or 256 states. The choice is made by a code selector sampled together with the start-of-packet strobe. Back-to-back packets may use different lengths with no other change in how the block is driven.

The trellis is worked by an array of 64 add-compare-select lanes. Each lane owns four adjacent states. The state metrics are stored in shuffle order: new state j is always reached from old states 2j mod S and 2j+1 mod S. This way every lane reads a contiguous window of eight old metrics, and the only thing that changes between state counts is the wrap of that window. Lanes that the current length does not need are held frozen. Each state carries a register-exchange survivor word that moves with its metric, so no traceback pass is needed.

After the packet's last tail symbol, the survivor word of state 0 is streamed out one bit per cycle, oldest bit first. A done flag marks the final bit.

Top module: `vit_top`

## Requirements
- R1: One trellis step is taken per accepted symbol (symValid high while a packet is running). A packet is 64 + K - 1 symbols. bitValid rises in the cycle after the clock edge that accepts the last symbol and stays high for exactly 64 consecutive cycles, carrying the decoded bits oldest first.
- R2: kSelIn, sampled with startIn, selects the code: 0 gives K=5 (generators 23 and 35 octal), 1 gives K=7 (171 and 133 octal), and 2 or 3 gives K=9 (561 and 753 octal). symIn[1] is the first generator's output and symIn[0] the second's. Each packet may use a different code.
- R3: Only the lanes needed by the selected length are active: 4 lanes for K=5, 16 for K=7 and 64 for K=9. An idle lane's metric and survivor registers do not change.
- R4: A packet encoded from the all-zero state, with the 64 information bits followed by K-1 zero tail bits and received without error, is decoded exactly.
- R5: A received packet with at most one flipped code bit in any 24 consecutive steps is still decoded exactly, for each code.
- R6: The branch metric is the Hamming distance (0 to 2) between the received pair and the expected pair. On equal candidate metrics, the predecessor with the lower state index is kept. The output equals a maximum-likelihood register-exchange decode with this tie rule, even under heavy bit errors.
- R7: startIn is ignored while a packet is in progress or being output. symValid is ignored outside the input phase of a packet.
- R8: done is high for exactly one cycle, coincident with the 64th output bit. A new start is accepted from the following cycle.
- R9: After reset, bitValid and done are low and the block waits for a start.
- R10: At packet start, state 0's metric is set to zero and every other active metric to a large value (default 100). Metrics are 8-bit and are rebased every step by subtracting the minimum of the active metrics they were computed from.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Start-of-packet strobe, honoured only while idle |
| kSelIn | input | 2 | Code selector sampled with startIn |
| symValid | input | 1 | A received symbol pair is present on symIn |
| symIn | input | 2 | Received hard-decision code bits of one step |
| bitValid | output | 1 | A decoded bit is on bitOut |
| bitOut | output | 1 | Decoded bit, oldest first |
| done | output | 1 | Marks the last decoded bit of the packet |

## Verification
The assertions take for granted that startIn is only raised while the block is idle or that any other pulse is truly dropped. They also take for granted that a packet always supplies its full symbol count before the next start, so the one-cycle done pulse and the 64-cycle output burst are never cut short. The stimulus keeps to this by waiting for each burst to end before issuing the next start. It deliberately pulses startIn mid-packet and drives symValid with junk while idle or draining, since both must be ignored. Random gaps in symValid exercise stalled steps without breaking the packet's symbol count.

// File: rtl/vit_pkg.sv
package vit_pkg;
  localparam int DEF_INFO_BITS = 64;
  localparam int DEF_MET_W = 8;
  localparam int OUT_IW = $clog2(DEF_INFO_BITS);

  typedef enum logic [1:0] {K_5 = 2'd0, K_7 = 2'd1, K_9 = 2'd2} kCode_e;

  typedef struct packed {
    logic init;
    logic step;
    logic infoStep;
    kCode_e kCode;
    logic [OUT_IW-1:0] outIdx;
  } ctlStrobe_t;

  function automatic int unsigned memOf(kCode_e k);
    case (k)
      K_5: return 4;
      K_7: return 6;
      default: return 8;
    endcase
  endfunction

  function automatic logic [8:0] polyA(kCode_e k);
    case (k)
      K_5: return 9'o023;
      K_7: return 9'o171;
      default: return 9'o561;
    endcase
  endfunction

  function automatic logic [8:0] polyB(kCode_e k);
    case (k)
      K_5: return 9'o035;
      K_7: return 9'o133;
      default: return 9'o753;
    endcase
  endfunction

  // expected code pair when bit u enters with older contents p
  function automatic logic [1:0] expPair(kCode_e k, logic u, logic [7:0] p);
    logic [8:0] w;
    int unsigned m;
    m = memOf(k);
    w = 9'(p) & 9'((1 << m) - 1);
    w = w | (9'(u) << m);
    return {^(w & polyA(k)), ^(w & polyB(k))};
  endfunction

  function automatic logic [1:0] hamming2(logic [1:0] a, logic [1:0] b);
    logic [1:0] x;
    x = a ^ b;
    return {1'b0, x[1]} + {1'b0, x[0]};
  endfunction
endpackage

// File: rtl/vit_acs_lane.sv
module vit_acs_lane #(
  parameter int LANE = 0,
  parameter int SPL = 4,
  parameter int MET_W = 8,
  parameter int SURV_W = 64,
  parameter int SIW = 8,
  parameter int BIG_MET = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic laneEn,
  input  logic doInit,
  input  logic doStep,
  input  logic infoStep,
  input  vit_pkg::kCode_e kCode,
  input  logic [1:0] sym,
  input  logic [MET_W-1:0] minOld,
  input  logic [2*SPL-1:0][MET_W-1:0] winMet,
  input  logic [2*SPL-1:0][SURV_W-1:0] winSurv,
  output logic [SPL-1:0][MET_W-1:0] met,
  output logic [SPL-1:0][SURV_W-1:0] surv
);
  localparam int BASE = LANE * SPL;
  localparam int CW = MET_W + 2;

  logic [SPL-1:0][MET_W-1:0] metNext;
  logic [SPL-1:0][SURV_W-1:0] survNext;

  always_comb begin
    for (int s = 0; s < SPL; s++) begin
      logic [SIW-1:0] jIdx, mask, p0, p1;
      logic u, pick1;
      int unsigned memLen;
      logic [CW-1:0] cand0, cand1, best, diff;
      logic [SURV_W-1:0] src;
      memLen = vit_pkg::memOf(kCode);
      mask = SIW'((1 << memLen) - 1);
      jIdx = SIW'(BASE + s);
      p0 = (jIdx << 1) & mask;
      p1 = p0 | SIW'(1);
      u = jIdx[memLen-1];
      cand0 = CW'(winMet[2*s]) + CW'(vit_pkg::hamming2(sym, vit_pkg::expPair(kCode, u, 8'(p0))));
      cand1 = CW'(winMet[2*s+1]) + CW'(vit_pkg::hamming2(sym, vit_pkg::expPair(kCode, u, 8'(p1))));
      pick1 = cand1 < cand0;
      best = pick1 ? cand1 : cand0;
      diff = best - CW'(minOld);
      metNext[s] = (diff > CW'({MET_W{1'b1}})) ? {MET_W{1'b1}} : diff[MET_W-1:0];
      src = pick1 ? winSurv[2*s+1] : winSurv[2*s];
      survNext[s] = infoStep ? {src[SURV_W-2:0], u} : src;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      met <= '0;
      surv <= '0;
    end else if (laneEn) begin
      if (doInit) begin
        for (int s = 0; s < SPL; s++) begin
          met[s] <= (BASE + s == 0) ? '0 : MET_W'(BIG_MET);
          surv[s] <= '0;
        end
      end else if (doStep) begin
        met <= metNext;
        surv <= survNext;
      end
    end
  end
endmodule

// File: rtl/vit_datapath.sv
module vit_datapath #(
  parameter int LANES = 64,
  parameter int SPL = 4,
  parameter int MET_W = 8,
  parameter int SURV_W = 64,
  parameter int BIG_MET = 100,
  localparam int STATES = LANES * SPL,
  localparam int SIW = $clog2(STATES)
) (
  input  logic clk,
  input  logic rstN,
  input  vit_pkg::ctlStrobe_t ctl,
  input  logic [1:0] sym,
  output logic bitOut,
  output logic [LANES-1:0] laneEn,
  output logic [STATES*MET_W-1:0] metricFlat
);
  logic [STATES-1:0][MET_W-1:0] metAll;
  logic [STATES-1:0][SURV_W-1:0] survAll;
  logic [MET_W-1:0] minOld;
  int liveStates;

  always_comb begin
    liveStates = 1 << vit_pkg::memOf(ctl.kCode);
    minOld = '1;
    for (int i = 0; i < STATES; i++) begin
      if (i < liveStates && metAll[i] < minOld) minOld = metAll[i];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [2*SPL-1:0][MET_W-1:0] winMet;
    logic [2*SPL-1:0][SURV_W-1:0] winSurv;
    logic [SPL-1:0][MET_W-1:0] laneMet;
    logic [SPL-1:0][SURV_W-1:0] laneSurv;

    assign laneEn[l] = (l * SPL) < liveStates;

    always_comb begin
      for (int i = 0; i < 2*SPL; i++) begin
        int idx;
        idx = (2 * l * SPL + i) & (liveStates - 1);
        winMet[i] = metAll[SIW'(idx)];
        winSurv[i] = survAll[SIW'(idx)];
      end
    end

    vit_acs_lane #(
      .LANE(l), .SPL(SPL), .MET_W(MET_W), .SURV_W(SURV_W),
      .SIW(SIW), .BIG_MET(BIG_MET)
    ) u_lane (
      .clk(clk), .rstN(rstN), .laneEn(laneEn[l]),
      .doInit(ctl.init), .doStep(ctl.step), .infoStep(ctl.infoStep),
      .kCode(ctl.kCode), .sym(sym), .minOld(minOld),
      .winMet(winMet), .winSurv(winSurv),
      .met(laneMet), .surv(laneSurv)
    );

    assign metAll[l*SPL +: SPL] = laneMet;
    assign survAll[l*SPL +: SPL] = laneSurv;
  end

  assign metricFlat = metAll;
  assign bitOut = survAll[0][~ctl.outIdx];
endmodule

// File: rtl/vit_ctrl.sv
module vit_ctrl #(
  parameter int INFO = 64,
  localparam int CW = $clog2(INFO + 16)
) (
  input  logic clk,
  input  logic rstN,
  input  logic startIn,
  input  logic [1:0] kSelIn,
  input  logic symValid,
  output vit_pkg::ctlStrobe_t ctl,
  output logic bitValid,
  output logic done
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} st_e;

  st_e st;
  vit_pkg::kCode_e kReg, kIn;
  logic [CW-1:0] stepCnt, lastStep;
  logic [vit_pkg::OUT_IW-1:0] outIdx;

  always_comb begin
    case (kSelIn)
      2'd0: kIn = vit_pkg::K_5;
      2'd1: kIn = vit_pkg::K_7;
      default: kIn = vit_pkg::K_9;
    endcase
    lastStep = CW'(INFO + int'(vit_pkg::memOf(kReg)) - 1);
    ctl.init = (st == ST_IDLE) && startIn;
    ctl.kCode = ctl.init ? kIn : kReg;
    ctl.step = (st == ST_RUN) && symValid;
    ctl.infoStep = stepCnt < CW'(INFO);
    ctl.outIdx = outIdx;
    bitValid = st == ST_DRAIN;
    done = (st == ST_DRAIN) && (outIdx == vit_pkg::OUT_IW'(INFO - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= ST_IDLE;
      kReg <= vit_pkg::K_5;
      stepCnt <= '0;
      outIdx <= '0;
    end else begin
      case (st)
        ST_IDLE: if (startIn) begin
          kReg <= kIn;
          stepCnt <= '0;
          st <= ST_RUN;
        end
        ST_RUN: if (symValid) begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == lastStep) begin
            st <= ST_DRAIN;
            outIdx <= '0;
          end
        end
        default: begin
          outIdx <= outIdx + 1'b1;
          if (done) st <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/vit_top.sv
module vit_top #(
  parameter int LANES = 64,
  parameter int SPL = 4,
  parameter int MET_W = vit_pkg::DEF_MET_W,
  parameter int INFO = vit_pkg::DEF_INFO_BITS,
  parameter int BIG_MET = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic startIn,
  input  logic [1:0] kSelIn,
  input  logic symValid,
  input  logic [1:0] symIn,
  output logic bitValid,
  output logic bitOut,
  output logic done
);
  localparam int STATES = LANES * SPL;

  vit_pkg::ctlStrobe_t ctl;
  logic ctlInit;
  logic [LANES-1:0] laneEn;
  logic [STATES*MET_W-1:0] metricFlat;

  vit_ctrl #(.INFO(INFO)) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .kSelIn(kSelIn),
    .symValid(symValid), .ctl(ctl), .bitValid(bitValid), .done(done)
  );

  vit_datapath #(
    .LANES(LANES), .SPL(SPL), .MET_W(MET_W), .SURV_W(INFO), .BIG_MET(BIG_MET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sym(symIn),
    .bitOut(bitOut), .laneEn(laneEn), .metricFlat(metricFlat)
  );

  assign ctlInit = ctl.init;
endmodule

// File: rtl/vit_chk.sv
module vit_chk #(
  parameter int LANES = 64,
  parameter int SPL = 4,
  parameter int MET_W = 8
) (
  input logic clk,
  input logic rstN,
  input logic bitValid,
  input logic done,
  input logic ctlInit,
  input logic [LANES-1:0] laneEn,
  input logic [LANES*SPL*MET_W-1:0] metricFlat
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_on_bit_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> bitValid);

  assert_burst_contig_R1: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !done) |=> bitValid);

  assert_init_origin_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctlInit |=> (metricFlat[MET_W-1:0] == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_hold
    assert_lane_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
      !laneEn[l] |=> $stable(metricFlat[l*SPL*MET_W +: SPL*MET_W]));
  end
endmodule

bind vit_top vit_chk u_chk (
  .clk(clk), .rstN(rstN), .bitValid(bitValid), .done(done),
  .ctlInit(ctlInit), .laneEn(laneEn), .metricFlat(metricFlat)
);

// File: tb/vit_top_tb.sv
`timescale 1ns/1ps
module vit_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [1:0] kSelIn = 2'd0;
  logic symValid = 1'b0;
  logic [1:0] symIn = 2'd0;
  logic bitValid, bitOut, done;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  bit finished = 1'b0;

  logic [1:0] txSyms [0:71];
  logic [1:0] rxSyms [0:71];

  always #2.5 clk = ~clk;

  vit_top u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .kSelIn(kSelIn),
    .symValid(symValid), .symIn(symIn),
    .bitValid(bitValid), .bitOut(bitOut), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  function automatic int memOfSel(int kSel);
    if (kSel == 0) return 4;
    if (kSel == 1) return 6;
    return 8;
  endfunction

  function automatic logic [1:0] encPair(int mem, logic u, logic [7:0] st);
    logic [8:0] w, ga, gb;
    case (mem)
      4: begin ga = 9'o023; gb = 9'o035; end
      6: begin ga = 9'o171; gb = 9'o133; end
      default: begin ga = 9'o561; gb = 9'o753; end
    endcase
    w = 9'(st) | (9'(u) << mem);
    return {^(w & ga), ^(w & gb)};
  endfunction

  function automatic int ham(logic [1:0] a, logic [1:0] b);
    return int'(a[1] ^ b[1]) + int'(a[0] ^ b[0]);
  endfunction

  // info bit 63 is the first bit sent
  task automatic buildTx(input int mem, input logic [63:0] info);
    logic [7:0] st;
    logic u;
    st = '0;
    for (int t = 0; t < 64 + mem; t++) begin
      u = (t < 64) ? info[63-t] : 1'b0;
      txSyms[t] = encPair(mem, u, st);
      rxSyms[t] = txSyms[t];
      st = (st >> 1) | (8'(u) << (mem - 1));
    end
  endtask

  function automatic logic [63:0] refDecode(int mem);
    int S, p, p0;
    int pm [256];
    int nm [256];
    logic [63:0] sv [256];
    logic [63:0] ns [256];
    logic u;
    int c0, c1;
    S = 1 << mem;
    for (int i = 0; i < 256; i++) begin
      pm[i] = (i == 0) ? 0 : 1000;
      sv[i] = '0;
    end
    for (int t = 0; t < 64 + mem; t++) begin
      for (int j = 0; j < S; j++) begin
        p0 = (2 * j) % S;
        u = ((j >> (mem - 1)) & 1) != 0;
        c0 = pm[p0] + ham(rxSyms[t], encPair(mem, u, 8'(p0)));
        c1 = pm[p0+1] + ham(rxSyms[t], encPair(mem, u, 8'(p0 + 1)));
        p = (c1 < c0) ? p0 + 1 : p0;
        nm[j] = (c1 < c0) ? c1 : c0;
        ns[j] = (t < 64) ? {sv[p][62:0], u} : sv[p];
      end
      for (int j = 0; j < S; j++) begin
        pm[j] = nm[j];
        sv[j] = ns[j];
      end
    end
    return sv[0];
  endfunction

  task automatic sendAndCollect(input int kSel, input int nSteps, input bit gaps,
                                input bit midStart, input bit junk,
                                output logic [63:0] got, output int terr);
    if (junk) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        symValid = 1'b1;
        symIn = 2'($urandom);
      end
    end
    @(negedge clk);
    symValid = 1'b0;
    startIn = 1'b1;
    kSelIn = 2'(kSel);
    @(negedge clk);
    startIn = 1'b0;
    for (int t = 0; t < nSteps; t++) begin
      if (gaps) begin
        while ($urandom % 4 == 0) begin
          symValid = 1'b0;
          symIn = 2'($urandom);
          @(negedge clk);
        end
      end
      symValid = 1'b1;
      symIn = rxSyms[t];
      if (midStart && t == 10) begin
        startIn = 1'b1;
        kSelIn = 2'(kSel + 1);
      end
      @(negedge clk);
      startIn = 1'b0;
    end
    symValid = 1'b0;
    terr = 0;
    for (int b = 0; b < 64; b++) begin
      if (!bitValid) terr++;
      if (done !== (b == 63)) terr++;
      got[63-b] = bitOut;
      if (junk) begin
        symValid = 1'b1;
        symIn = 2'($urandom);
      end
      @(negedge clk);
    end
    symValid = 1'b0;
    if (bitValid || done) terr++;
  endtask

  task automatic doPacket(input int kSel, input string req, input bit useRef,
                          input logic [63:0] info, input bit gaps,
                          input bit midStart, input bit junk);
    int mem, terr;
    logic [63:0] got, exp;
    mem = memOfSel(kSel);
    exp = useRef ? refDecode(mem) : info;
    sendAndCollect(kSel, 64 + mem, gaps, midStart, junk, got, terr);
    check(got === exp, req, "decoded word", got, exp);
    check(terr == 0, "R1/R8", "output burst timing errors", 64'(terr), 64'd0);
  endtask

  function automatic logic [63:0] rand64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    logic [63:0] info;
    int seedDummy;
    seedDummy = $urandom(32'd5150);
    repeat (3) @(negedge clk);
    // R9: idle outputs in and after reset
    check(bitValid == 1'b0 && done == 1'b0, "R9", "outputs in reset",
          {62'd0, bitValid, done}, 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(bitValid == 1'b0 && done == 1'b0, "R9", "outputs after reset",
          {62'd0, bitValid, done}, 64'd0);

    // R4: directed clean packets, one per code
    info = 64'd0;
    buildTx(4, info); doPacket(0, "R4", 1'b0, info, 1'b0, 1'b0, 1'b0);
    info = '1;
    buildTx(6, info); doPacket(1, "R4", 1'b0, info, 1'b0, 1'b0, 1'b0);
    info = 64'hAAAA_AAAA_AAAA_AAAA;
    buildTx(8, info); doPacket(2, "R4", 1'b0, info, 1'b0, 1'b0, 1'b0);
    // R2: selector 3 behaves as K=9
    info = rand64();
    buildTx(8, info); doPacket(3, "R2", 1'b0, info, 1'b0, 1'b0, 1'b0);
    // R2/R3: switching lengths between packets, with stalls
    for (int r = 0; r < 2; r++) begin
      for (int k = 2; k >= 0; k--) begin
        info = rand64();
        buildTx(memOfSel(k), info);
        doPacket(k, "R2/R3", 1'b0, info, 1'b1, 1'b0, 1'b0);
      end
    end
    // R5: sparse errors corrected
    for (int k = 0; k < 3; k++) begin
      int mem;
      mem = memOfSel(k);
      info = rand64();
      buildTx(mem, info);
      for (int t = 3; t < 64 + mem; t += 24) rxSyms[t] = rxSyms[t] ^ 2'(1 << ($urandom % 2));
      doPacket(k, "R5", 1'b0, info, 1'b0, 1'b0, 1'b0);
    end
    // R6: heavy noise against a reference decode with the tie rule
    for (int r = 0; r < 2; r++) begin
      for (int k = 0; k < 3; k++) begin
        int mem;
        mem = memOfSel(k);
        info = rand64();
        buildTx(mem, info);
        for (int t = 0; t < 64 + mem; t++)
          rxSyms[t] = rxSyms[t] ^ {($urandom % 6 == 0), ($urandom % 6 == 0)};
        doPacket(k, "R6", 1'b1, info, 1'b1, 1'b0, 1'b0);
      end
    end
    // R6: all-ones received stream, many ties
    buildTx(6, 64'd0);
    for (int t = 0; t < 70; t++) rxSyms[t] = 2'b11;
    doPacket(1, "R6", 1'b1, 64'd0, 1'b0, 1'b0, 1'b0);
    // R7: mid-packet start and stray symbols ignored
    info = rand64();
    buildTx(6, info); doPacket(1, "R7", 1'b0, info, 1'b0, 1'b1, 1'b1);
    info = rand64();
    buildTx(4, info); doPacket(0, "R7", 1'b0, info, 1'b1, 1'b1, 1'b1);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule